// File: doc/BRIEF.md
# Time-Base Interrupt and Standby Controller

This block turns a free-running 32768 Hz low-frequency clock into four periodic ticks (fast, display-service, medium and slow). It gathers them, together with a timer carry and an external interrupt pin, into six interrupt flags that sit behind an enable register. Flags are set in the system clock domain. Software clears them by writing ones to the bits it wants to clear.

The same block owns the CPU power state. A write to the stop register gates the CPU clock and records which wake sources are armed: the key port, the timer carry and the slow tick. An armed source then restarts the clock and issues a one-cycle CPU reset. The block's own registers, such as enables and pending flags, are left as they were, in the same way that RAM and I/O are preserved. A watchdog expects a clear write between consecutive slow ticks. If one is missing, it raises a system reset request and forces the run state.

Top module: `tbwake_ctrl`

## Requirements
- R1: After reset, all six flags read 0, `cpu_clk_en_o` is 1, and both `cpu_rst_o` and `sys_rst_o` are 0.
- R2: Flag bit positions are fixed as follows:
  - bit 0: timer carry
  - bit 1: fast tick
  - bit 2: display-service tick
  - bit 3: medium tick
  - bit 4: external pin
  - bit 5: slow tick

  Each tick source fires once every 2^TAP low-frequency cycles (TAP_FAST, TAP_LCD, TAP_MID, TAP_SLOW; defaults 4, 7, 8 and 14 give 2048, 256, 128 and 2 Hz).
- R3: With enable bit 0 set, a one-cycle `tmr_carry_i` pulse sets flag 0 at the next system clock edge.
- R4: A rising edge on `ext_irq_i` sets flag 4 after a two-stage synchronizer. A level held high does not set it again once it has been cleared.
- R5: A source whose enable bit is 0 leaves its flag at 0.
- R6: A flag-clear write clears exactly the flags whose data bits are 1. A source event in the same cycle wins over the clear.
- R7: A stop write in the run state drops `cpu_clk_en_o` from the next cycle and latches the wake mask from `stop_wdata_i`: bit 0 arms the key port, bit 1 the timer carry, bit 2 the slow tick.
- R8: In standby, an armed wake event causes a single-cycle `cpu_rst_o` while `cpu_clk_en_o` returns to 1. Any synchronized key high counts as a key event. Flags and enables keep their values.
- R9: In standby, a wake source whose mask bit is 0 has no effect, and the clock stays off.
- R10: If `wdt_clr_i` is pulsed at least once between consecutive slow ticks, `sys_rst_o` never asserts.
- R11: A slow tick that arrives with no clear since the previous slow tick asserts `sys_rst_o` for one cycle. This repeats at every later slow tick until a clear arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lf | input | 1 | 32768 Hz time-base clock |
| clk_sys | input | 1 | Free-running system clock (source of the gated CPU clock) |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| tmr_carry_i | input | 1 | Timer overflow pulse, system domain |
| ext_irq_i | input | 1 | External interrupt pin, asynchronous |
| key_i | input | KEY_W | Key wake port, asynchronous levels |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 6 | Enable register write data |
| flag_clr_we_i | input | 1 | Flag clear write strobe |
| flag_clr_data_i | input | 6 | Write-one-to-clear mask |
| stop_we_i | input | 1 | Stop register write strobe |
| stop_wdata_i | input | 3 | Wake mask written with the stop command |
| wdt_clr_i | input | 1 | Watchdog clear write strobe |
| irq_flags_o | output | 6 | Pending interrupt flags |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| cpu_rst_o | output | 1 | Wake reset pulse to the CPU |
| sys_rst_o | output | 1 | Watchdog system reset request |

## Verification
The hardest situations to reach are the watchdog expiry and the slow-tick wake. Both depend on the phase of a tick that comes thousands of cycles apart at default settings. The bench therefore shrinks every tap so that the slow tick falls every 64 low-frequency cycles. It holds the low-frequency clock at an exact ratio to the system clock and offsets its edges from the system edges, which makes the synchronizer delay constant and tick spacing an exact cycle count. A background process services the watchdog throughout the other tests. Stopping that service lets the bench measure both the delay from the last clear to the first reset and the spacing between repeated resets.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
    localparam int NSRC    = 6;
    localparam int SRC_TMR = 0;
    localparam int SRC_FST = 1;
    localparam int SRC_LCD = 2;
    localparam int SRC_MID = 3;
    localparam int SRC_EXT = 4;
    localparam int SRC_SLW = 5;

    localparam int WK_KEY = 0;
    localparam int WK_TMR = 1;
    localparam int WK_SLW = 2;
    localparam int WK_W   = 3;

    typedef enum logic {
        PW_RUN  = 1'b0,
        PW_STBY = 1'b1
    } pw_state_e;
endpackage

// File: rtl/tbw_divider.sv
module tbw_divider #(
    parameter int TAP_FAST = 4,
    parameter int TAP_LCD  = 7,
    parameter int TAP_MID  = 8,
    parameter int TAP_SLOW = 14
) (
    input  logic       clk_lf,
    input  logic       rst_n,
    output logic [3:0] taps_o
);
    localparam int M1    = (TAP_FAST > TAP_LCD) ? TAP_FAST : TAP_LCD;
    localparam int M2    = (TAP_MID > TAP_SLOW) ? TAP_MID : TAP_SLOW;
    localparam int CNT_W = (M1 > M2) ? M1 : M2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d     = div_q;
        div_d.cnt = div_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_lf or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // a tap bit rises once every 2^TAP low-frequency cycles
    assign taps_o = {div_q.cnt[TAP_SLOW-1], div_q.cnt[TAP_MID-1],
                     div_q.cnt[TAP_LCD-1],  div_q.cnt[TAP_FAST-1]};
endmodule

// File: rtl/tbw_sync.sv
module tbw_sync #(
    parameter int NEDGE = 5,
    parameter int NLVL  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NEDGE+NLVL-1:0] in_i,
    output logic [NEDGE-1:0]      rise_o,
    output logic [NLVL-1:0]       lvl_o
);
    localparam int NW = NEDGE + NLVL;

    typedef struct packed {
        logic [NW-1:0]    s1;
        logic [NW-1:0]    s2;
        logic [NEDGE-1:0] s3;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = in_i;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2[NEDGE-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    // one-cycle pulse per synchronized rising edge on the low bits
    genvar g;
    generate
        for (g = 0; g < NEDGE; g++) begin : g_edge
            assign rise_o[g] = sy_q.s2[g] & ~sy_q.s3[g];
        end
    endgenerate

    assign lvl_o = sy_q.s2[NW-1:NEDGE];
endmodule

// File: rtl/tbw_irq_flags.sv
module tbw_irq_flags
    import tbw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic            en_we_i,
    input  logic [NSRC-1:0] en_wdata_i,
    input  logic            clr_we_i,
    input  logic [NSRC-1:0] clr_data_i,
    output logic [NSRC-1:0] flags_o,
    output logic [NSRC-1:0] en_o
);
    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] flags;
    } irq_t;

    irq_t ir_d, ir_q;
    logic [NSRC-1:0] clr_mask;

    always_comb begin
        ir_d     = ir_q;
        clr_mask = clr_we_i ? clr_data_i : '0;
        if (en_we_i) ir_d.en = en_wdata_i;
        // a new event overrides a simultaneous clear
        ir_d.flags = (ir_q.flags & ~clr_mask) | (evt_i & ir_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ir_q <= '0;
        else        ir_q <= ir_d;
    end

    assign flags_o = ir_q.flags;
    assign en_o    = ir_q.en;
endmodule

// File: rtl/tbw_power.sv
module tbw_power
    import tbw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stop_we_i,
    input  logic [WK_W-1:0] stop_wdata_i,
    input  logic            key_any_i,
    input  logic            tmr_carry_i,
    input  logic            slow_tick_i,
    input  logic            wdt_clr_i,
    output logic            cpu_clk_en_o,
    output logic            cpu_rst_o,
    output logic            sys_rst_o
);
    typedef struct packed {
        pw_state_e       state;
        logic [WK_W-1:0] mask;
        logic            wd_pend;
        logic            cpu_rst;
        logic            sys_rst;
    } pw_t;

    pw_t  pw_d, pw_q;
    logic wake;
    logic timeout;

    always_comb begin
        pw_d         = pw_q;
        pw_d.cpu_rst = 1'b0;
        pw_d.sys_rst = 1'b0;

        wake = (pw_q.mask[WK_KEY] & key_any_i)
             | (pw_q.mask[WK_TMR] & tmr_carry_i)
             | (pw_q.mask[WK_SLW] & slow_tick_i);

        // a clear in the tick cycle still counts as service
        timeout = slow_tick_i & pw_q.wd_pend & ~wdt_clr_i;
        if (wdt_clr_i)   pw_d.wd_pend = 1'b0;
        if (slow_tick_i) pw_d.wd_pend = 1'b1;

        if (timeout) begin
            pw_d.sys_rst = 1'b1;
            pw_d.state   = PW_RUN;
        end else begin
            unique case (pw_q.state)
                PW_RUN: begin
                    if (stop_we_i) begin
                        pw_d.state = PW_STBY;
                        pw_d.mask  = stop_wdata_i;
                    end
                end
                PW_STBY: begin
                    if (wake) begin
                        pw_d.state   = PW_RUN;
                        pw_d.cpu_rst = 1'b1;
                    end
                end
                default: pw_d.state = PW_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pw_q <= '{state: PW_RUN, default: '0};
        else        pw_q <= pw_d;
    end

    assign cpu_clk_en_o = (pw_q.state == PW_RUN);
    assign cpu_rst_o    = pw_q.cpu_rst;
    assign sys_rst_o    = pw_q.sys_rst;
endmodule

// File: rtl/tbwake_ctrl.sv
module tbwake_ctrl
    import tbw_pkg::*;
#(
    parameter int TAP_FAST = 4,
    parameter int TAP_LCD  = 7,
    parameter int TAP_MID  = 8,
    parameter int TAP_SLOW = 14,
    parameter int KEY_W    = 6
) (
    input  logic             clk_lf,
    input  logic             clk_sys,
    input  logic             rst_n,
    input  logic             tmr_carry_i,
    input  logic             ext_irq_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic             en_we_i,
    input  logic [NSRC-1:0]  en_wdata_i,
    input  logic             flag_clr_we_i,
    input  logic [NSRC-1:0]  flag_clr_data_i,
    input  logic             stop_we_i,
    input  logic [WK_W-1:0]  stop_wdata_i,
    input  logic             wdt_clr_i,
    output logic [NSRC-1:0]  irq_flags_o,
    output logic             cpu_clk_en_o,
    output logic             cpu_rst_o,
    output logic             sys_rst_o
);
    localparam int NEDGE = 5;

    logic [3:0]       taps;
    logic [NEDGE-1:0] rise;
    logic [KEY_W-1:0] key_lvl;
    logic [NSRC-1:0]  evt;
    logic [NSRC-1:0]  en_q;

    tbw_divider #(
        .TAP_FAST(TAP_FAST), .TAP_LCD(TAP_LCD),
        .TAP_MID(TAP_MID),   .TAP_SLOW(TAP_SLOW)
    ) div_i (
        .clk_lf (clk_lf),
        .rst_n  (rst_n),
        .taps_o (taps)
    );

    // edge bits: 0 fast, 1 display, 2 medium, 3 external, 4 slow
    tbw_sync #(.NEDGE(NEDGE), .NLVL(KEY_W)) sync_i (
        .clk    (clk_sys),
        .rst_n  (rst_n),
        .in_i   ({key_i, taps[3], ext_irq_i, taps[2], taps[1], taps[0]}),
        .rise_o (rise),
        .lvl_o  (key_lvl)
    );

    always_comb begin
        evt          = '0;
        evt[SRC_TMR] = tmr_carry_i;
        evt[SRC_FST] = rise[0];
        evt[SRC_LCD] = rise[1];
        evt[SRC_MID] = rise[2];
        evt[SRC_EXT] = rise[3];
        evt[SRC_SLW] = rise[4];
    end

    tbw_irq_flags flags_i (
        .clk        (clk_sys),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .en_we_i    (en_we_i),
        .en_wdata_i (en_wdata_i),
        .clr_we_i   (flag_clr_we_i),
        .clr_data_i (flag_clr_data_i),
        .flags_o    (irq_flags_o),
        .en_o       (en_q)
    );

    tbw_power power_i (
        .clk          (clk_sys),
        .rst_n        (rst_n),
        .stop_we_i    (stop_we_i),
        .stop_wdata_i (stop_wdata_i),
        .key_any_i    (|key_lvl),
        .tmr_carry_i  (tmr_carry_i),
        .slow_tick_i  (rise[4]),
        .wdt_clr_i    (wdt_clr_i),
        .cpu_clk_en_o (cpu_clk_en_o),
        .cpu_rst_o    (cpu_rst_o),
        .sys_rst_o    (sys_rst_o)
    );
endmodule

// File: rtl/tbwake_ctrl_chk.sv
module tbwake_ctrl_chk
    import tbw_pkg::*;
(
    input logic            clk_sys,
    input logic            rst_n,
    input logic            stop_we_i,
    input logic            cpu_clk_en_o,
    input logic            cpu_rst_o,
    input logic            sys_rst_o,
    input logic [NSRC-1:0] irq_flags_o,
    input logic [NSRC-1:0] en_q
);
    p_stop_gates_r7: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (stop_we_i && cpu_clk_en_o) |=> (!cpu_clk_en_o || sys_rst_o));

    p_wake_single_r8: assert property (@(posedge clk_sys) disable iff (!rst_n)
        cpu_rst_o |=> !cpu_rst_o);

    p_wake_clk_on_r8: assert property (@(posedge clk_sys) disable iff (!rst_n)
        cpu_rst_o |-> cpu_clk_en_o);

    p_sleep_hold_r9: assert property (@(posedge clk_sys) disable iff (!rst_n)
        !cpu_clk_en_o |=> (!cpu_clk_en_o || cpu_rst_o || sys_rst_o));

    p_wd_single_r11: assert property (@(posedge clk_sys) disable iff (!rst_n)
        sys_rst_o |=> !sys_rst_o);

    p_wd_run_r11: assert property (@(posedge clk_sys) disable iff (!rst_n)
        sys_rst_o |-> cpu_clk_en_o);

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_src
            p_flag_needs_en_r5: assert property (@(posedge clk_sys) disable iff (!rst_n)
                (!irq_flags_o[g] && !en_q[g]) |=> !irq_flags_o[g]);
        end
    endgenerate
endmodule

bind tbwake_ctrl tbwake_ctrl_chk chk_i (
    .clk_sys      (clk_sys),
    .rst_n        (rst_n),
    .stop_we_i    (stop_we_i),
    .cpu_clk_en_o (cpu_clk_en_o),
    .cpu_rst_o    (cpu_rst_o),
    .sys_rst_o    (sys_rst_o),
    .irq_flags_o  (irq_flags_o),
    .en_q         (en_q)
);

// File: tb/tbwake_ctrl_tb.sv
module tbwake_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LF_RATIO   = 8;
    localparam int LF_HALF    = CLK_PERIOD * LF_RATIO / 2;
    localparam int T_FAST = 2, T_LCD = 3, T_MID = 4, T_SLOW = 6;
    localparam int KEY_W  = 6;
    localparam int SLOW_CYC = (1 << T_SLOW) * LF_RATIO;

    logic clk_sys = 0, clk_lf = 0, rst_n = 0;
    logic tmr_carry = 0, ext_irq = 0;
    logic [KEY_W-1:0] key = '0;
    logic en_we = 0, clr_we = 0, stop_we = 0, wdt_clr = 0;
    logic [5:0] en_wdata = '0, clr_data = '0;
    logic [2:0] stop_wdata = '0;
    logic [5:0] flags;
    logic clk_en, cpu_rst, sys_rst;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, cpu_rst_cnt = 0, sys_rst_cnt = 0;
    bit wd_service = 1;
    bit done = 0;

    tbwake_ctrl #(.TAP_FAST(T_FAST), .TAP_LCD(T_LCD), .TAP_MID(T_MID),
                  .TAP_SLOW(T_SLOW), .KEY_W(KEY_W)) dut_i (
        .clk_lf(clk_lf), .clk_sys(clk_sys), .rst_n(rst_n),
        .tmr_carry_i(tmr_carry), .ext_irq_i(ext_irq), .key_i(key),
        .en_we_i(en_we), .en_wdata_i(en_wdata),
        .flag_clr_we_i(clr_we), .flag_clr_data_i(clr_data),
        .stop_we_i(stop_we), .stop_wdata_i(stop_wdata), .wdt_clr_i(wdt_clr),
        .irq_flags_o(flags), .cpu_clk_en_o(clk_en),
        .cpu_rst_o(cpu_rst), .sys_rst_o(sys_rst)
    );

    initial forever #(CLK_PERIOD/2) clk_sys = ~clk_sys;
    initial begin #3; forever #(LF_HALF) clk_lf = ~clk_lf; end

    always @(posedge clk_sys) cyc <= cyc + 1;
    always @(negedge clk_sys) begin
        if (cpu_rst) cpu_rst_cnt <= cpu_rst_cnt + 1;
        if (sys_rst) sys_rst_cnt <= sys_rst_cnt + 1;
    end

    // background watchdog service, one pulse every 100 cycles
    initial begin
        int k = 0;
        forever begin
            @(negedge clk_sys);
            k = (k == 99) ? 0 : k + 1;
            wdt_clr = wd_service && (k == 0);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_sys);
    endtask

    task automatic write_en(input logic [5:0] v);
        en_we = 1; en_wdata = v; clr_we = 1; clr_data = 6'h3f;
        tick(1);
        en_we = 0; clr_we = 0;
    endtask

    task automatic clear(input logic [5:0] v);
        clr_we = 1; clr_data = v;
        tick(1);
        clr_we = 0;
    endtask

    task automatic carry;
        tmr_carry = 1;
        tick(1);
        tmr_carry = 0;
    endtask

    task automatic stop(input logic [2:0] m);
        stop_we = 1; stop_wdata = m;
        tick(1);
        stop_we = 0;
        check(clk_en == 0, "R7 clock gated after stop", clk_en, 0);
    endtask

    task automatic wait_rise(input int idx, output int t);
        t = -1;
        for (int i = 0; i < 5000; i++) begin
            if (flags[idx]) begin t = cyc; break; end
            tick(1);
        end
    endtask

    task automatic period(input int idx, input int tap);
        int t1, t2;
        write_en(6'(1 << idx));
        wait_rise(idx, t1);
        clear(6'(1 << idx));
        wait_rise(idx, t2);
        check(t1 >= 0 && t2 - t1 == (1 << tap) * LF_RATIO,
              $sformatf("R2 period of flag %0d", idx), t2 - t1, (1 << tap) * LF_RATIO);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int base, t1, t2;
        tick(3);
        check(flags == 0, "R1 flags at reset", flags, 0);
        check(clk_en == 1, "R1 clock enable at reset", clk_en, 1);
        check(cpu_rst == 0, "R1 cpu reset idle", cpu_rst, 0);
        check(sys_rst == 0, "R1 system reset idle", sys_rst, 0);
        rst_n = 1;
        tick(2);

        // R5: everything disabled, ticks and carry must not set flags
        write_en(6'h00);
        tick(2 * SLOW_CYC);
        carry();
        tick(2);
        check(flags == 0, "R5 disabled sources ignored", flags, 0);

        // R3: timer carry
        write_en(6'h01);
        carry();
        check(flags[0] == 1, "R3 carry sets flag 0", flags[0], 1);

        // R4 / R6: external edge and write-one-to-clear
        write_en(6'h11);
        carry();
        ext_irq = 1;
        tick(5);
        check(flags == 6'h11, "R4 external edge sets flag 4", flags, 6'h11);
        clear(6'h01);
        check(flags == 6'h10, "R6 clear only selected bit", flags, 6'h10);
        clear(6'h10);
        tick(20);
        check(flags == 0, "R4 held level does not re-set", flags, 0);
        ext_irq = 0;
        tick(4);
        carry();
        tmr_carry = 1; clr_we = 1; clr_data = 6'h01;
        tick(1);
        tmr_carry = 0; clr_we = 0;
        check(flags[0] == 1, "R6 set wins over clear", flags[0], 1);

        // R2: tick periods
        period(1, T_FAST);
        period(2, T_LCD);
        period(3, T_MID);
        period(5, T_SLOW);

        // R7 / R9 / R8: key wake with other sources masked
        write_en(6'h01);
        carry();
        base = cpu_rst_cnt;
        stop(3'b001);
        carry();
        tick(2 * SLOW_CYC);
        check(clk_en == 0 && cpu_rst_cnt == base, "R9 masked sources ignored", clk_en, 0);
        check(cpu_rst_cnt == base, "R9 no wake reset", cpu_rst_cnt - base, 0);
        key = 6'b000100;
        tick(6);
        check(cpu_rst_cnt == base + 1, "R8 key wake single reset", cpu_rst_cnt - base, 1);
        check(clk_en == 1, "R8 clock restored", clk_en, 1);
        check(flags[0] == 1, "R8 flags preserved", flags[0], 1);
        key = '0;
        tick(4);

        // R8: timer carry wake
        base = cpu_rst_cnt;
        stop(3'b010);
        tick(3);
        carry();
        tick(3);
        check(cpu_rst_cnt == base + 1 && clk_en == 1, "R8 timer wake", cpu_rst_cnt - base, 1);

        // R8: slow tick wake
        base = cpu_rst_cnt;
        stop(3'b100);
        t1 = 0;
        for (int i = 0; i < SLOW_CYC + 50; i++) begin
            if (clk_en) break;
            tick(1);
        end
        tick(2);
        check(cpu_rst_cnt == base + 1 && clk_en == 1, "R8 slow tick wake", cpu_rst_cnt - base, 1);

        // R10: serviced watchdog never fired during all of the above
        check(sys_rst_cnt == 0, "R10 serviced watchdog quiet", sys_rst_cnt, 0);

        // R11: stop servicing
        wd_service = 0;
        tick(1);
        base = sys_rst_cnt;
        tick(SLOW_CYC - 110);
        check(sys_rst_cnt == base, "R11 no reset before second tick", sys_rst_cnt - base, 0);
        t1 = -1;
        for (int i = 0; i < SLOW_CYC + 150; i++) begin
            if (sys_rst) begin t1 = cyc; break; end
            tick(1);
        end
        check(t1 >= 0, "R11 reset after missed service", t1 >= 0, 1);
        tick(1);
        t2 = -1;
        for (int i = 0; i < SLOW_CYC + 50; i++) begin
            if (sys_rst) begin t2 = cyc; break; end
            tick(1);
        end
        check(t2 - t1 == SLOW_CYC, "R11 reset repeats each slow tick", t2 - t1, SLOW_CYC);
        wd_service = 1;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule